// File: doc/BRIEF.md
# ECG R-Peak Detector

This block finds R peaks in a stream of smoothed 12-bit ECG samples that arrive with a valid strobe at about 2 kHz. A sample is declared an R peak only when three tests agree on the same sample. First, enough samples must have passed since the previous peak. Second, the candidate must lie above a programmable threshold. Third, the candidate must be a local maximum over a sliding window of 25 samples.

Alongside the detection, the block counts the R-R interval in samples. On each peak it raises a one-cycle marker, which can drive a DAC marker level. It also presents the interval that has just ended, so a later stage can turn it into beats per minute. Smoothing, rate division and display are handled elsewhere.

The refractory length defaults to 500 samples. This is a quarter of a second at 2 kHz, which caps detection at 240 bpm. The interval counter saturates, so a lost signal cannot produce a short false interval.

Top module: `rpeak_detector`

## Requirements
- R1: The window is a shift register of WIN_LEN (default 25) stages that are zero after reset. Each valid sample enters stage 0 and moves every stage up by one. The candidate is the centre stage, index WIN_LEN/2 (12 by default).
- R2: The interval count rises by one per valid sample. Cycles with `smp_valid` low change neither the count nor the window, whatever `smp_data` holds.
- R3: No peak is declared unless the count including the current sample exceeds HOLDOFF (default 500).
- R4: No peak is declared unless the candidate is strictly greater than `thresh`. A candidate equal to the threshold is rejected.
- R5: The candidate qualifies as a maximum only if it is greater than or equal to every other window stage. A flat top of equal values is therefore accepted, and a smaller bump within half a window of a larger one is rejected.
- R6: All tests use the window after the current valid sample has shifted in. `peak_pulse` is high for exactly the one clock cycle after that sample's clock edge.
- R7: With `peak_pulse`, `rr_interval` shows the number of valid samples from the previous detection sample (or from reset) through this one, and holds that value until the next peak.
- R8: The interval count is cleared to zero by each detection.
- R9: The interval count saturates at 2**CNT_W-1 instead of wrapping.
- R10: After reset, `peak_pulse` and `rr_interval` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe marking a new sample on `smp_data` |
| smp_data | input | 12 | Smoothed ECG sample, unsigned |
| thresh | input | 12 | Amplitude threshold; the candidate must exceed it |
| peak_pulse | output | 1 | One-cycle marker for a detected R peak |
| rr_interval | output | CNT_W | Finished R-R interval in samples, held between peaks |

## Verification
The cases hardest to reach from the ports need long quiet stretches or finely placed pulses. Saturation needs more samples between peaks than the counter can hold. The bench uses an 8-bit counter and a holdoff of 20, so a run of 300 zero samples reaches saturation cheaply. The flat-top and near-bump cases need exact pulse shapes: a plateau of three equal samples, and a 150-high bump directly ahead of a 300-high peak. These are placed so both lie inside one 25-sample window. Throughout, a bench model of the window and counter predicts every cycle, and the valid strobe is also broken up with idle cycles that carry garbage data.

// File: rtl/rpk_pkg.sv
package rpk_pkg;

    localparam int SMP_W = 12;

    typedef logic [SMP_W-1:0] sample_t;

    // Result of the three peak tests for one sample
    typedef struct packed {
        logic armed;    // refractory interval elapsed
        logic above;    // candidate exceeds threshold
        logic is_max;   // candidate is a plateau-tolerant maximum
    } qual_t;

    function automatic int centre_of(input int len);
        return len / 2;
    endfunction

    function automatic logic all_pass(input qual_t q);
        return q.armed & q.above & q.is_max;
    endfunction

endpackage

// File: rtl/rpk_window.sv
module rpk_window
    import rpk_pkg::*;
#(
    parameter int WIN_LEN = 25
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    shift_en,
    input  sample_t din,
    output sample_t centre_next,
    output logic    is_max_next
);
    localparam int CIDX = centre_of(WIN_LEN);

    sample_t win_q  [WIN_LEN];
    sample_t win_nx [WIN_LEN];
    logic [WIN_LEN-1:0] ge;

    // window as it looks once din has shifted in
    assign win_nx[0] = din;
    genvar gi;
    generate
        for (gi = 1; gi < WIN_LEN; gi++) begin : g_shift
            assign win_nx[gi] = win_q[gi-1];
        end
        for (gi = 0; gi < WIN_LEN; gi++) begin : g_cmp
            if (gi == CIDX) begin : g_self
                assign ge[gi] = 1'b1;
            end else begin : g_other
                assign ge[gi] = (win_nx[CIDX] >= win_nx[gi]);
            end
        end
    endgenerate

    assign centre_next = win_nx[CIDX];
    assign is_max_next = &ge;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WIN_LEN; i++) win_q[i] <= '0;
        end else if (shift_en) begin
            for (int i = 0; i < WIN_LEN; i++) win_q[i] <= win_nx[i];
        end
    end

    // R1: newest sample lands in stage 0
    a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> win_q[0] == $past(din));
    // R2: window frozen without a valid sample
    a_r2_hold_window: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> win_q[CIDX] == $past(win_q[CIDX]));

endmodule

// File: rtl/rpk_interval.sv
module rpk_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_incl
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // count including the sample arriving now, saturating
    assign cnt_incl = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= clear ? '0 : cnt_incl;
        end
    end

    // R8: cleared by a detection
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (tick && clear) |=> cnt_q == '0);
    // R9: stays at the top once reached
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
    // R2: no change without a sample
    a_r2_idle_count: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/rpk_qualify.sv
module rpk_qualify
    import rpk_pkg::*;
#(
    parameter int HOLDOFF = 500,
    parameter int CNT_W   = 16
) (
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_incl,
    input  sample_t          centre,
    input  sample_t          thresh,
    input  logic             is_max,
    output logic             fire
);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLDOFF);

    qual_t q;

    always_comb begin
        q.armed  = (cnt_incl > HOLD_LIM);
        q.above  = (centre > thresh);
        q.is_max = is_max;
        fire     = tick & all_pass(q);
    end

endmodule

// File: rtl/rpeak_detector.sv
module rpeak_detector
    import rpk_pkg::*;
#(
    parameter int WIN_LEN = 25,
    parameter int HOLDOFF = 500,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [11:0]      smp_data,
    input  logic [11:0]      thresh,
    output logic             peak_pulse,
    output logic [CNT_W-1:0] rr_interval
);
    sample_t          centre;
    logic             is_max;
    logic             fire;
    logic [CNT_W-1:0] cnt_incl;

    rpk_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk         (clk),
        .rst         (rst),
        .shift_en    (smp_valid),
        .din         (smp_data),
        .centre_next (centre),
        .is_max_next (is_max)
    );

    rpk_interval #(.CNT_W(CNT_W)) u_interval (
        .clk      (clk),
        .rst      (rst),
        .tick     (smp_valid),
        .clear    (fire),
        .cnt_incl (cnt_incl)
    );

    rpk_qualify #(.HOLDOFF(HOLDOFF), .CNT_W(CNT_W)) u_qualify (
        .tick     (smp_valid),
        .cnt_incl (cnt_incl),
        .centre   (centre),
        .thresh   (thresh),
        .is_max   (is_max),
        .fire     (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            peak_pulse  <= 1'b0;
            rr_interval <= '0;
        end else begin
            peak_pulse <= fire;
            if (fire) rr_interval <= cnt_incl;
        end
    end

    // R6: marker lasts one cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        peak_pulse |=> !peak_pulse);
    // R6: marker only follows a valid sample
    a_r6_after_valid: assert property (@(posedge clk) disable iff (rst)
        peak_pulse |-> $past(smp_valid));
    // R3: refractory interval respected
    a_r3_refractory: assert property (@(posedge clk) disable iff (rst)
        peak_pulse |-> rr_interval > CNT_W'(HOLDOFF));
    // R7: interval held between peaks
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !peak_pulse |-> $stable(rr_interval));

endmodule

// File: tb/rpeak_detector_bench.sv
module rpeak_detector_bench;
    localparam int WL  = 25;
    localparam int HO  = 20;
    localparam int CW  = 8;
    localparam int CMX = 255;
    localparam int CI  = WL / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [11:0]   smp_data = '0;
    logic [11:0]   thresh = 12'd100;
    logic          peak_pulse;
    logic [CW-1:0] rr_interval;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int mwin [WL];
    int mcnt = 0;
    int exp_rr = 0;
    int npk = 0;
    int last_rr = 0;
    bit gap_mode = 0;

    always #5 clk = ~clk;

    rpeak_detector #(.WIN_LEN(WL), .HOLDOFF(HO), .CNT_W(CW)) u_rpeak_detector (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .thresh(thresh), .peak_pulse(peak_pulse), .rr_interval(rr_interval)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle, predict, compare after the edge
    task automatic cycle(input bit v, input int d);
        bit epk = 0;
        @(negedge clk);
        smp_valid = v;
        smp_data  = 12'(d);
        if (v) begin
            int incl;
            bit mx = 1;
            for (int i = WL-1; i > 0; i--) mwin[i] = mwin[i-1];
            mwin[0] = d;
            incl = (mcnt == CMX) ? CMX : mcnt + 1;
            for (int i = 0; i < WL; i++) if (mwin[i] > mwin[CI]) mx = 0;
            if (incl > HO && mwin[CI] > int'(thresh) && mx) begin
                epk = 1; exp_rr = incl; mcnt = 0;
            end else mcnt = incl;
        end
        @(posedge clk);
        #1;
        check(peak_pulse == epk, "R6 peak_pulse vs model (R3 R4 R5)", int'(peak_pulse), int'(epk));
        check(int'(rr_interval) == exp_rr, "R7 rr_interval vs model (R8 R9)", int'(rr_interval), exp_rr);
        if (peak_pulse) begin npk++; last_rr = int'(rr_interval); end
    endtask

    task automatic smp(input int d);
        if (gap_mode) cycle(1'b0, 4000);   // R2: garbage while invalid
        cycle(1'b1, d);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) smp(0);
    endtask

    // 3 rising, flat top of `flat` samples, 3 falling
    task automatic pulse(input int top, input int flat);
        for (int i = 3; i > 0; i--) smp(top - 30*i);
        for (int i = 0; i < flat; i++) smp(top);
        for (int i = 1; i <= 3; i++) smp(top - 30*i);
    endtask

    initial begin
        for (int i = 0; i < WL; i++) mwin[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        check(peak_pulse == 1'b0, "R10 reset peak_pulse", int'(peak_pulse), 0);
        check(rr_interval == '0, "R10 reset rr_interval", int'(rr_interval), 0);
        @(negedge clk);
        rst = 1'b0;

        // two peaks 25 samples apart
        zeros(40); npk = 0;
        pulse(300, 1); zeros(18); pulse(300, 1); zeros(30);
        check(npk == 2, "R5 two separated peaks", npk, 2);
        check(last_rr == 25, "R7 interval of 25 samples", last_rr, 25);

        // second peak 10 samples later is inside the refractory span
        npk = 0;
        pulse(300, 1); zeros(3); pulse(300, 1); zeros(30);
        check(npk == 1, "R3 refractory blocks second peak", npk, 1);

        // threshold equality rejected, one above accepted
        thresh = 12'd300; npk = 0;
        pulse(300, 1); zeros(30);
        check(npk == 0, "R4 top equal to threshold", npk, 0);
        pulse(301, 1); zeros(30);
        check(npk == 1, "R4 top above threshold", npk, 1);
        thresh = 12'd100;

        // flat top of three equal samples
        npk = 0;
        pulse(300, 3); zeros(30);
        check(npk == 1, "R5 plateau gives one peak", npk, 1);

        // small bump just ahead of larger peak
        npk = 0;
        pulse(150, 1); pulse(300, 1); zeros(30);
        check(npk == 1, "R5 smaller neighbour rejected", npk, 1);

        // saturation
        zeros(300); npk = 0;
        pulse(300, 1); zeros(30);
        check(last_rr == CMX, "R9 saturated interval", last_rr, CMX);

        // idle cycles with garbage between samples
        gap_mode = 1; npk = 0;
        pulse(300, 1); zeros(18); pulse(300, 1); zeros(30);
        check(last_rr == 25, "R2 idle cycles not counted", last_rr, 25);
        gap_mode = 0;

        // sweep of spacings and heights against the model
        for (int s = 12; s <= 40; s += 2) begin
            thresh = 12'(90 + 7*s);
            pulse(200 + 5*s, 1 + (s % 3));
            zeros(s);
        end
        zeros(30);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule